// File: doc/BRIEF.md
# Store Queue with Read Bypass

This block sits between a write-through cache and a slow memory port. Every store the processor performs goes into the cache and into this queue. The queue alone brings memory up to date, one word at a time, while the processor keeps running. It holds up to `DEPTH` entries, and each entry is a word address plus its data. When the queue is full, `wr_ready` drops and the producer must wait.

When the cache misses on a read, it hands the miss address to the block. The block compares that address with every occupied entry in the same cycle.
- **Match:** the data of the youngest matching entry is returned on the next cycle, marked as forwarded, and memory is not touched.
- **No match:** the read is held as a pending request. It takes the memory port at the next free slot, ahead of every queued write. Only a write that has already been presented to memory finishes first.

A dirty block that is being replaced is pushed through the same write port before the miss read is issued. The read therefore reaches memory first and the victim is written afterwards.

The memory port is a plain request/acknowledge link. `mem_req` and the fields that go with it stay steady until `mem_ack` is seen.

Top module: `wbuf_bypass`

## Requirements
- R1: After reset `wr_ready` and `rd_ready` are 1, and `mem_req` and `rsp_valid` are 0.
- R2: An accepted store is written to memory with its own address and data, with `mem_we`=1, and only one memory operation is outstanding at a time.
- R3: Stores leave the queue in arrival order, and two stores to the same address stay separate entries. After draining, memory holds the value of the later store.
- R4: While `DEPTH` entries are held, `wr_ready` is 0. A `wr_valid` presented then is not stored and never reaches memory.
- R5: A read whose address matches no entry is sent to memory (`mem_we`=0) before every queued write except one already presented. Its response carries the memory word with `rsp_fwd`=0.
- R6: A read that matches an entry is answered on the clock edge after acceptance with the youngest matching data and `rsp_fwd`=1, and no memory read is made for it.
- R7: A victim pushed into the queue before its miss read is issued is written to memory after that read.
- R8: Once `mem_req` is 1, it and `mem_we`, `mem_addr` and `mem_wdata` hold their values until the cycle in which `mem_ack` is 1.
- R9: A response to a memory read appears on the clock edge after the one at which `mem_ack` is sampled.
- R10: `rd_ready` is 0 while a read is waiting for or holding the memory port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Store or victim write offered |
| wr_ready | output | 1 | Queue can take a write |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | DW | Write data |
| rd_valid | input | 1 | Read-miss request offered |
| rd_ready | output | 1 | Read request can be taken |
| rd_addr | input | AW | Word address of the read miss |
| rsp_valid | output | 1 | Read response valid for one cycle |
| rsp_fwd | output | 1 | Response came from the queue |
| rsp_data | output | DW | Read response data |
| mem_req | output | 1 | Memory operation requested |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory completes the operation |
| mem_rdata | input | DW | Memory read data, valid with `mem_ack` |

## Verification
The expected delay of each result is fixed:
- A forwarded response is due exactly one edge after the read is accepted, so the bench samples it at the falling edge right after that acceptance.
- A memory-read response is due one edge after `mem_ack`. The bench records whether an acknowledged read was visible at the falling edge just before the response and requires it.
- Write drain and read priority depend on how long memory takes, so they are not checked against a cycle. They are checked against the order of operations logged by the memory model.

The memory model can stall its acknowledge. During a stall the queue fills, forwarding is exercised, and the presented request is checked for steadiness. This makes the expected order independent of timing.

// File: rtl/wbuf_bypass.sv
module wbuf_bypass #(
  parameter int AW    = 30,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [AW-1:0] rd_addr,
  output logic          rsp_valid,
  output logic          rsp_fwd,
  output logic [DW-1:0] rsp_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] q_addr [DEPTH];
  logic [DW-1:0] q_data [DEPTH];
  logic [PW-1:0] rp, wp;
  logic [CW-1:0] cnt;

  logic          busy, cur_rd;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_data;
  logic          rd_pend;
  logic [AW-1:0] rd_paddr;

  logic          hit;
  logic [DW-1:0] hit_data;

  assign wr_ready  = (cnt != CW'(DEPTH));
  assign rd_ready  = !rd_pend && !(busy && cur_rd);
  assign mem_req   = busy;
  assign mem_we    = !cur_rd;
  assign mem_addr  = cur_addr;
  assign mem_wdata = cur_data;

  wire push     = wr_valid && wr_ready;
  wire pop      = busy && !cur_rd && mem_ack;
  wire rd_acc   = rd_valid && rd_ready;
  wire issue_rd = !busy && rd_pend;
  wire issue_wr = !busy && !rd_pend && (cnt != '0);

  // oldest to youngest; the last match wins
  always_comb begin
    logic [PW-1:0] k;
    hit      = 1'b0;
    hit_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      k = rp + PW'(i);
      if ((CW'(i) < cnt) && (q_addr[k] == rd_addr)) begin
        hit      = 1'b1;
        hit_data = q_data[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      q_addr[wp] <= wr_addr;
      q_data[wp] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp        <= '0;
      wp        <= '0;
      cnt       <= '0;
      busy      <= 1'b0;
      cur_rd    <= 1'b0;
      cur_addr  <= '0;
      cur_data  <= '0;
      rd_pend   <= 1'b0;
      rd_paddr  <= '0;
      rsp_valid <= 1'b0;
      rsp_fwd   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);

      if (rd_acc) begin
        if (hit) begin
          rsp_valid <= 1'b1;
          rsp_fwd   <= 1'b1;
          rsp_data  <= hit_data;
        end else begin
          rd_pend  <= 1'b1;
          rd_paddr <= rd_addr;
        end
      end

      if (busy && mem_ack) begin
        busy <= 1'b0;
        if (cur_rd) begin
          rsp_valid <= 1'b1;
          rsp_fwd   <= 1'b0;
          rsp_data  <= mem_rdata;
        end
      end else if (issue_rd) begin
        busy     <= 1'b1;
        cur_rd   <= 1'b1;
        cur_addr <= rd_paddr;
        rd_pend  <= 1'b0;
      end else if (issue_wr) begin
        busy     <= 1'b1;
        cur_rd   <= 1'b0;
        cur_addr <= q_addr[rp];
        cur_data <= q_data[rp];
      end
    end
  end

  p_full_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready && !(mem_req && mem_we && mem_ack)) |=> !wr_ready);

  p_rd_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend && !mem_req) |=> (mem_req && !mem_we));

  p_fwd_no_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fwd) |-> !(mem_req && !mem_we));

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  p_rsp_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> (rsp_valid && !rsp_fwd));

  p_rd_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> !rd_ready);
endmodule

// File: tb/wbuf_bypass_bench.sv
module wbuf_bypass_bench;
  localparam int AW = 30;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, rd_valid = 1'b0, mem_ack = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, mem_rdata = '0;
  logic wr_ready, rd_ready, rsp_valid, rsp_fwd, mem_req, mem_we;
  logic [DW-1:0] rsp_data, mem_wdata;
  logic [AW-1:0] mem_addr;

  always #10 clk = ~clk;

  wbuf_bypass u_wbuf_bypass (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_fwd(rsp_fwd), .rsp_data(rsp_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int checks = 0, fails = 0;
  logic hold = 1'b0;
  int lat = 2, wcnt = 0;
  logic [DW-1:0] mem [16];
  logic          lg_we   [32];
  logic [AW-1:0] lg_addr [32];
  logic [DW-1:0] lg_data [32];
  int log_n = 0;

  function automatic logic [DW-1:0] init_val(int a);
    return 32'hA000_0000 + a;
  endfunction

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: drives 5 ns after the rising edge
  initial begin
    for (int i = 0; i < 16; i++) mem[i] = init_val(i);
    forever begin
      @(posedge clk); #5;
      if (!mem_req) begin
        mem_ack = 1'b0; wcnt = 0;
      end else if (!mem_ack && !hold) begin
        if (wcnt >= lat) begin
          mem_ack = 1'b1; wcnt = 0;
          if (log_n < 32) begin
            lg_we[log_n] = mem_we; lg_addr[log_n] = mem_addr; lg_data[log_n] = mem_wdata;
          end
          log_n++;
          if (mem_we) mem[mem_addr[3:0]] = mem_wdata;
          else mem_rdata = mem[mem_addr[3:0]];
        end else wcnt++;
      end
    end
  end

  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(posedge clk); @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd_issue(input logic [AW-1:0] a);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a;
    while (!rd_ready) @(negedge clk);
    @(posedge clk); @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic rd_wait(input logic [DW-1:0] exp, input string req);
    logic prev_ack = 1'b0;
    for (int n = 0; n < 300 && !rsp_valid; n++) begin
      prev_ack = mem_req && !mem_we && mem_ack;
      @(negedge clk);
    end
    check(rsp_valid && !rsp_fwd && rsp_data == exp, req, rsp_data, exp);
    check(prev_ack, "R9 response one edge after read ack", prev_ack, 1);
  endtask

  task automatic wait_log(input int n);
    for (int k = 0; k < 500 && !(log_n >= n && !mem_req); k++) @(negedge clk);
  endtask

  task automatic finish_up;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  typedef struct packed { logic rd; logic [AW-1:0] a; logic [DW-1:0] d; } vec_t;
  localparam vec_t VEC [6] = '{
    '{1'b0, 30'd1, 32'h0000_0111},
    '{1'b0, 30'd2, 32'h0000_0222},
    '{1'b0, 30'd1, 32'h0000_0333},
    '{1'b1, 30'd1, 32'h0000_0333},
    '{1'b1, 30'd2, 32'h0000_0222},
    '{1'b0, 30'd3, 32'h0000_0444}
  };

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(wr_ready == 1 && rd_ready == 1, "R1 ready after reset", {wr_ready, rd_ready}, 2'b11);
    check(mem_req == 0 && rsp_valid == 0, "R1 idle after reset", {mem_req, rsp_valid}, 0);
    rst_n = 1'b1;

    // phase A: memory stalled, fill queue, forward reads
    hold = 1'b1;
    foreach (VEC[i]) begin
      if (!VEC[i].rd) push(VEC[i].a, VEC[i].d);
      else begin
        rd_issue(VEC[i].a);
        check(rsp_valid && rsp_fwd && rsp_data == VEC[i].d, "R6 forward youngest match",
              {rsp_valid, rsp_fwd, rsp_data}, {2'b11, VEC[i].d});
      end
    end
    check(mem_req && mem_we && mem_addr == 1 && mem_wdata == 32'h111, "R8 request held while stalled",
          {mem_req, mem_we, mem_addr}, {2'b11, 30'd1});
    check(!wr_ready, "R4 full drops wr_ready", wr_ready, 0);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 5; wr_data = 32'h555;
    repeat (5) @(negedge clk);
    check(!wr_ready, "R4 stays full", wr_ready, 0);
    wr_valid = 1'b0;

    rd_issue(7);
    check(!rsp_valid, "R5 miss not forwarded", rsp_valid, 0);
    check(!rd_ready, "R10 rd_ready low while read pending", rd_ready, 0);
    hold = 1'b0;
    rd_wait(init_val(7), "R5 miss read data");
    wait_log(5);
    check(log_n == 5, "R4 only queued writes drained", log_n, 5);
    check(lg_we[0] && lg_addr[0] == 1 && lg_data[0] == 32'h111, "R2 first write", lg_data[0], 32'h111);
    check(!lg_we[1] && lg_addr[1] == 7, "R5 read ahead of queued writes", {lg_we[1], lg_addr[1]}, 7);
    check(lg_we[2] && lg_addr[2] == 2 && lg_data[2] == 32'h222, "R3 order entry 2", lg_data[2], 32'h222);
    check(lg_we[3] && lg_addr[3] == 1 && lg_data[3] == 32'h333, "R3 order entry 3", lg_data[3], 32'h333);
    check(lg_we[4] && lg_addr[4] == 3 && lg_data[4] == 32'h444, "R3 order entry 4", lg_data[4], 32'h444);
    check(mem[1] == 32'h333, "R3 memory holds later store", mem[1], 32'h333);
    check(mem[5] == init_val(5), "R4 write while full ignored", mem[5], init_val(5));
    check(wr_ready && rd_ready, "R10 ready again after drain", {wr_ready, rd_ready}, 2'b11);

    rd_issue(1);
    rd_wait(32'h333, "R3 read back newest from memory");

    // phase B: dirty victim pushed before its miss read
    wait_log(6);
    hold = 1'b1;
    push(10, 32'hAAA);
    push(9, 32'h999);
    rd_issue(12);
    check(!rd_ready, "R10 rd_ready low behind write", rd_ready, 0);
    hold = 1'b0;
    rd_wait(init_val(12), "R7 miss read data");
    wait_log(9);
    check(lg_we[6] && lg_addr[6] == 10, "R2 in-flight write completes first", lg_addr[6], 10);
    check(!lg_we[7] && lg_addr[7] == 12, "R7 read before victim", {lg_we[7], lg_addr[7]}, 12);
    check(lg_we[8] && lg_addr[8] == 9 && lg_data[8] == 32'h999, "R7 victim written after read", lg_data[8], 32'h999);
    check(mem[9] == 32'h999, "R7 victim in memory", mem[9], 32'h999);
    finish_up();
  end
endmodule